// File: doc/BRIEF.md
# Multi-Slice Edge Timestamping Engine

The engine watches a bus of input lines arranged in groups of 32, called slices. Each input passes through a two-flop synchroniser, and every slice compares the sampled value with the sample from the cycle before. Only the lines that the slice's enable mask selects take part in this comparison. When an enabled line changes, the slice records one event. The event holds a 64-bit free-running tick count, the slice index, and the masked slice value before and after the change. Events queue in a FIFO. Software reads the oldest event through a small register window and retires it with an explicit pop command. Software finds every line that changed by XOR of the two snapshots. The global line number is the slice index times 32 plus the bit position.

A level interrupt tells software that the FIFO occupancy has reached a programmable threshold. Several slices can change in the same cycle. In that case each slice holds its event in a pending stage, and the events drain into the FIFO in ascending slice order, one per cycle. Each event keeps the tick of the cycle in which its change was detected. The counter is meant to tick at 31.25 MHz, so a consumer gets nanoseconds by shifting the tick value left by 5.

Top module: `edge_stamp_engine`

## Requirements
- R1: The 64-bit tick counter is zero after reset and advances by one on every clock. Each input passes two synchronising flops. An event's tick is the counter value in the cycle in which the synchronised change is compared against the previous sample.
- R2: A change on any enabled line of slice k produces one event. Software reads the event at these offsets: tick bits 63:32 at 0x4, tick bits 31:0 at 0x8, slice index in bits 23:16 of 0x0C, value after the change at 0x10, value before the change at 0x14. Disabled bits read as zero in both snapshots. A change on a disabled line produces no event.
- R3: Several enabled lines of one slice that change in the same cycle produce a single event.
- R4: Events from several slices in the same cycle enter the FIFO in ascending slice order, one per cycle, each with its own detection tick.
- R5: If a slice changes again while its event is still waiting, the waiting event keeps its tick and its before value and takes the newest after value.
- R6: The control register at 0x0 holds the global enable in bit 0, the interrupt enable in bit 1 and the threshold in bits 15:8. After reset it reads 0x100. While the global enable is 0, no new events are taken.
- R7: The enable mask of slice k is read and written at 0x40 + 0x20*k. Changing a mask by itself creates no event.
- R8: The status register at 0x20 reports the FIFO occupancy in bits 15:8.
- R9: Writing exactly 1 to 0x1C removes the oldest event. Any other value has no effect, and a pop on an empty FIFO is ignored. The event registers read 0 while the FIFO is empty.
- R10: An event that arrives while the FIFO is full is dropped and sets status bit 0. Writing 1 to that bit clears it. If a drop and a clear fall in the same cycle, the drop wins.
- R11: irq_o is high exactly when the global enable and the interrupt enable are both set and the occupancy is at or above the threshold.
- R12: If an event is pushed and a pop is taken in the same cycle, the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | NUM_SLICES*32 | Monitored lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Three pairs of functions can land on the same cycle: the FIFO push and a software pop, the drain of one slice and a new change on another slice, and an overflow drop and the clearing write to the overflow bit. The bench times a pop write so that it hits the very edge on which a synchronised edge is pushed. It also drives two slices together and then changes the waiting slice a cycle later. A behavioural queue model runs alongside the design on every clock, and both the interrupt and the register that is addressed are compared against that model each cycle.

// File: rtl/ese_pkg.sv
package ese_pkg;
  localparam int SLICE_W = 32;
  localparam int TS_W    = 64;

  typedef struct packed {
    logic [TS_W-1:0]    ts;
    logic [7:0]         slice;
    logic [SLICE_W-1:0] prev;
    logic [SLICE_W-1:0] cur;
  } ese_entry_t;

  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_TS_HI   = 8'h04;
  localparam logic [7:0] OFF_TS_LO   = 8'h08;
  localparam logic [7:0] OFF_SRC     = 8'h0C;
  localparam logic [7:0] OFF_CUR     = 8'h10;
  localparam logic [7:0] OFF_PREV    = 8'h14;
  localparam logic [7:0] OFF_CMD     = 8'h1C;
  localparam logic [7:0] OFF_STAT    = 8'h20;
  localparam logic [7:0] OFF_MASK0   = 8'h40;
  localparam logic [7:0] MASK_STRIDE = 8'h20;
endpackage

// File: rtl/ese_sync.sv
module ese_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ese_slice_track.sv
module ese_slice_track
  import ese_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLICE_W-1:0] now_i,
  input  logic [SLICE_W-1:0] last_i,
  input  logic [SLICE_W-1:0] mask_i,
  input  logic               arm_i,
  input  logic               grant_i,
  input  logic [TS_W-1:0]    ts_i,
  output logic               pend_o,
  output ese_entry_t         ent_o
);
  logic       pend_q;
  ese_entry_t ent_q;
  logic       chg;

  assign chg = arm_i && (|((now_i ^ last_i) & mask_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ent_q  <= '0;
    end else if (chg) begin
      if (pend_q && !grant_i) begin
        // still waiting: keep tick and before-value, refresh after-value
        ent_q.cur <= now_i & mask_i;
      end else begin
        pend_q <= 1'b1;
        ent_q  <= '{ts: ts_i, slice: 8'(IDX), prev: last_i & mask_i, cur: now_i & mask_i};
      end
    end else if (grant_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ent_o  = ent_q;
endmodule

// File: rtl/ese_fifo.sv
module ese_fifo
  import ese_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  ese_entry_t din_i,
  input  logic       pop_i,
  output ese_entry_t head_o,
  output logic [CW-1:0] count_o,
  output logic       full_o,
  output logic       empty_o
);
  ese_entry_t    mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = empty_o ? '0 : mem[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/edge_stamp_engine.sv
module edge_stamp_engine
  import ese_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SLICES*SLICE_W-1:0] lines_i,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic                          irq_o
);
  localparam int NL = NUM_SLICES * SLICE_W;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [NL-1:0]      sync_w, last_q;
  logic [TS_W-1:0]    ts_q;
  logic               en_q, ie_q, ovf_q;
  logic [7:0]         thr_q;
  logic [SLICE_W-1:0] mask_q [NUM_SLICES];
  logic [NUM_SLICES-1:0] pend, grant;
  ese_entry_t         ents [NUM_SLICES];
  ese_entry_t         sel_ent, head;
  logic [CW-1:0]      occ;
  logic               full, empty, push, drop, pop_cmd, stat_clr;

  function automatic logic [ADDR_W-1:0] mask_addr(int k);
    return ADDR_W'(OFF_MASK0) + ADDR_W'(k) * ADDR_W'(MASK_STRIDE);
  endfunction

  ese_sync #(.W(NL)) sync_i (.clk_i, .rst_ni, .d_i(lines_i), .q_o(sync_w));

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    ese_slice_track #(.IDX(k)) trk_i (
      .clk_i, .rst_ni,
      .now_i  (sync_w[k*SLICE_W +: SLICE_W]),
      .last_i (last_q[k*SLICE_W +: SLICE_W]),
      .mask_i (mask_q[k]),
      .arm_i  (en_q),
      .grant_i(grant[k]),
      .ts_i   (ts_q),
      .pend_o (pend[k]),
      .ent_o  (ents[k])
    );
  end

  // lowest pending slice drains first
  always_comb begin
    grant   = '0;
    sel_ent = '0;
    for (int k = NUM_SLICES - 1; k >= 0; k--) begin
      if (pend[k]) begin
        grant   = '0;
        grant[k] = 1'b1;
        sel_ent = ents[k];
      end
    end
  end

  assign push     = |grant;
  assign drop     = push && full;
  assign pop_cmd  = wr_en_i && (addr_i == ADDR_W'(OFF_CMD)) && (wdata_i == 32'd1);
  assign stat_clr = wr_en_i && (addr_i == ADDR_W'(OFF_STAT)) && wdata_i[0];

  ese_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i (push),
    .din_i  (sel_ent),
    .pop_i  (pop_cmd),
    .head_o (head),
    .count_o(occ),
    .full_o (full),
    .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      ts_q   <= '0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      thr_q  <= 8'd1;
      ovf_q  <= 1'b0;
      for (int k = 0; k < NUM_SLICES; k++) mask_q[k] <= '0;
    end else begin
      last_q <= sync_w;
      ts_q   <= ts_q + 1'b1;
      if (wr_en_i && addr_i == ADDR_W'(OFF_CTRL)) begin
        en_q  <= wdata_i[0];
        ie_q  <= wdata_i[1];
        thr_q <= wdata_i[15:8];
      end
      for (int k = 0; k < NUM_SLICES; k++)
        if (wr_en_i && addr_i == mask_addr(k)) mask_q[k] <= wdata_i;
      if (drop)          ovf_q <= 1'b1;
      else if (stat_clr) ovf_q <= 1'b0;
    end
  end

  assign irq_o = en_q && ie_q && (32'(occ) >= 32'(thr_q));

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(OFF_CTRL))  rdata_o = {16'b0, thr_q, 6'b0, ie_q, en_q};
    else if (addr_i == ADDR_W'(OFF_TS_HI)) rdata_o = head.ts[63:32];
    else if (addr_i == ADDR_W'(OFF_TS_LO)) rdata_o = head.ts[31:0];
    else if (addr_i == ADDR_W'(OFF_SRC))   rdata_o = {8'b0, head.slice, 16'b0};
    else if (addr_i == ADDR_W'(OFF_CUR))   rdata_o = head.cur;
    else if (addr_i == ADDR_W'(OFF_PREV))  rdata_o = head.prev;
    else if (addr_i == ADDR_W'(OFF_STAT))  rdata_o = {16'b0, 8'(occ), 7'b0, ovf_q};
    else begin
      for (int k = 0; k < NUM_SLICES; k++)
        if (addr_i == mask_addr(k)) rdata_o = mask_q[k];
    end
  end
endmodule

// File: rtl/ese_checker.sv
module ese_checker #(
  parameter int NUM_SLICES = 2,
  parameter int FIFO_DEPTH = 16,
  parameter int CW = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CW-1:0]         occ_i,
  input logic                  full_i,
  input logic                  push_i,
  input logic                  pop_cmd_i,
  input logic                  stat_clr_i,
  input logic [NUM_SLICES-1:0] grant_i,
  input logic                  ovf_i,
  input logic                  en_i,
  input logic                  irq_i
);
  assert_occ_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(occ_i) <= FIFO_DEPTH);

  assert_one_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  assert_full_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i && push_i |=> ovf_i);

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !stat_clr_i |=> ovf_i);

  assert_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i == '0) && !push_i |=> occ_i == '0);

  assert_push_pop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !full_i && pop_cmd_i && (occ_i != '0) |=> occ_i == $past(occ_i));

  assert_no_irq_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_i);
endmodule

bind edge_stamp_engine ese_checker #(
  .NUM_SLICES(NUM_SLICES), .FIFO_DEPTH(FIFO_DEPTH), .CW(CW)
) chk_i (
  .clk_i, .rst_ni,
  .occ_i(occ), .full_i(full), .push_i(push), .pop_cmd_i(pop_cmd),
  .stat_clr_i(stat_clr), .grant_i(grant), .ovf_i(ovf_q), .en_i(en_q), .irq_i(irq_o)
);

// File: tb/edge_stamp_engine_tb_top.sv
module edge_stamp_engine_tb_top;
  localparam int NS = 2;
  localparam int DEPTH = 16;
  localparam int NL = NS * 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NL-1:0] lines = '0;
  logic          wr = 0;
  logic [7:0]    addr = 8'h20;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0, errors = 0;
  string phase = "R6";

  always #4 clk = ~clk;

  edge_stamp_engine #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic [63:0] ts; logic [7:0] sl; logic [31:0] pv; logic [31:0] cv;
  } ent_t;

  logic [NL-1:0] m_s1, m_s2, m_last;
  logic [63:0]   m_ts;
  bit            m_en, m_ie, m_ovf;
  logic [7:0]    m_thr;
  logic [31:0]   m_mask [NS];
  bit            m_pend [NS];
  ent_t          m_pe   [NS];
  ent_t          m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_last = '0; m_ts = '0;
      m_en = 0; m_ie = 0; m_ovf = 0; m_thr = 8'd1;
      m_q.delete();
      for (int k = 0; k < NS; k++) begin m_mask[k] = '0; m_pend[k] = 0; m_pe[k] = '0; end
    end else begin
      int g;
      bit full, popit, chg;
      logic [31:0] nw, ls;
      g = -1;
      for (int k = 0; k < NS; k++) if (m_pend[k] && g < 0) g = k;
      full  = (m_q.size() == DEPTH);
      popit = wr && addr == 8'h1C && wdata == 32'd1 && m_q.size() > 0;
      if (popit) void'(m_q.pop_front());
      if (g >= 0 && !full) m_q.push_back(m_pe[g]);
      for (int k = 0; k < NS; k++) begin
        nw  = m_s2[k*32 +: 32];
        ls  = m_last[k*32 +: 32];
        chg = m_en && (((nw ^ ls) & m_mask[k]) != 0);
        if (chg) begin
          if (m_pend[k] && g != k) m_pe[k].cv = nw & m_mask[k];
          else begin
            m_pend[k] = 1;
            m_pe[k] = '{ts: m_ts, sl: 8'(k), pv: ls & m_mask[k], cv: nw & m_mask[k]};
          end
        end else if (g == k) m_pend[k] = 0;
      end
      if (g >= 0 && full) m_ovf = 1;
      else if (wr && addr == 8'h20 && wdata[0]) m_ovf = 0;
      if (wr && addr == 8'h00) begin m_en = wdata[0]; m_ie = wdata[1]; m_thr = wdata[15:8]; end
      for (int k = 0; k < NS; k++) if (wr && addr == 8'h40 + 8'(k * 32)) m_mask[k] = wdata;
      m_last = m_s2; m_s2 = m_s1; m_s1 = lines;
      m_ts = m_ts + 1;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    ent_t h = (m_q.size() > 0) ? m_q[0] : '0;
    case (a)
      8'h00: return {16'b0, m_thr, 6'b0, m_ie, m_en};
      8'h04: return h.ts[63:32];
      8'h08: return h.ts[31:0];
      8'h0C: return {8'b0, h.sl, 16'b0};
      8'h10: return h.cv;
      8'h14: return h.pv;
      8'h20: return {16'b0, 8'(m_q.size()), 7'b0, m_ovf};
      default: begin
        for (int k = 0; k < NS; k++) if (a == 8'h40 + 8'(k * 32)) return m_mask[k];
        return 32'h0;
      end
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " R11 irq"}, {31'b0, irq},
          {31'b0, m_en && m_ie && (m_q.size() >= int'(m_thr))});
      chk({phase, " read"}, rdata, m_read(addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2; wr = 1; addr = a; wdata = d;
    @(posedge clk); #2; wr = 0; addr = 8'h20;
  endtask

  task automatic peek(logic [7:0] a);
    @(posedge clk); #2; addr = a;
  endtask

  task automatic peek_lit(string tag, logic [7:0] a, logic [31:0] exp);
    peek(a); @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic set_lines(logic [NL-1:0] v);
    @(posedge clk); #2; lines = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic dump_head();
    peek(8'h04); peek(8'h08); peek(8'h0C); peek(8'h10); peek(8'h14); peek(8'h20);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); #2; rst_n = 1;
    // R6 R8 reset state
    phase = "R6";
    peek_lit("R6 ctrl reset", 8'h00, 32'h0000_0100);
    peek_lit("R8 status reset", 8'h20, 32'h0);
    peek_lit("R1 empty head tick", 8'h08, 32'h0);

    // R7 masks
    phase = "R7";
    wr_reg(8'h40, 32'hFFFF_FFFF);
    wr_reg(8'h60, 32'h0000_00FF);
    peek_lit("R7 mask1 readback", 8'h60, 32'h0000_00FF);
    wr_reg(8'h00, 32'h0000_0103);

    // R1 R2 single line
    phase = "R2";
    set_lines(64'h8);
    idle(6);
    peek_lit("R8 occupancy one", 8'h20, 32'h0000_0100);
    peek_lit("R2 cur", 8'h10, 32'h8);
    peek_lit("R2 prev", 8'h14, 32'h0);
    peek_lit("R2 src", 8'h0C, 32'h0);
    phase = "R1"; dump_head();
    phase = "R9"; wr_reg(8'h1C, 32'd1);
    peek_lit("R9 popped", 8'h20, 32'h0);

    // R3 several lines in one slice
    phase = "R3";
    set_lines(64'h29);
    idle(6);
    peek_lit("R3 single entry", 8'h20, 32'h0000_0100);
    dump_head();
    wr_reg(8'h1C, 32'd1);

    // R2 disabled line in slice 1
    phase = "R2";
    set_lines(64'h0010_0000_0000_0029);
    idle(6);
    peek_lit("R2 disabled line ignored", 8'h20, 32'h0);

    // R7 mask change alone
    phase = "R7";
    wr_reg(8'h60, 32'hFFFF_FFFF);
    idle(5);
    peek_lit("R7 mask change no event", 8'h20, 32'h0);

    // R4 two slices together
    phase = "R4";
    set_lines(64'h0010_0002_0000_002B);
    idle(6);
    peek_lit("R4 two entries", 8'h20, 32'h0000_0200);
    peek_lit("R4 slice0 first", 8'h0C, 32'h0);
    dump_head();
    wr_reg(8'h1C, 32'd1);
    peek_lit("R4 slice1 second", 8'h0C, 32'h0001_0000);
    dump_head();
    wr_reg(8'h1C, 32'd1);

    // R5 merge into a waiting slice
    phase = "R5";
    set_lines(64'h0010_0003_0000_002A);
    set_lines(64'h0010_0007_0000_002A);
    idle(6);
    peek_lit("R5 two entries", 8'h20, 32'h0000_0200);
    wr_reg(8'h1C, 32'd1);
    peek_lit("R5 merged cur", 8'h10, 32'h0010_0007);
    peek_lit("R5 kept prev", 8'h14, 32'h0010_0002);
    dump_head();
    wr_reg(8'h1C, 32'd1);

    // R6 global disable
    phase = "R6";
    wr_reg(8'h00, 32'h0000_0102);
    set_lines(64'h0);
    idle(6);
    peek_lit("R6 disabled no event", 8'h20, 32'h0);
    wr_reg(8'h00, 32'h0000_0303);

    // R11 threshold 3
    phase = "R11";
    set_lines(64'h1); idle(1);
    set_lines(64'h0); idle(1);
    idle(4);
    peek_lit("R11 below threshold", 8'h20, 32'h0000_0200);
    set_lines(64'h1);
    idle(6);
    peek_lit("R11 at threshold", 8'h20, 32'h0000_0300);

    // R12 push and pop on the same edge
    phase = "R12";
    set_lines(64'h0);
    idle(2);
    wr_reg(8'h1C, 32'd1);
    idle(3);
    peek_lit("R12 occupancy held", 8'h20, 32'h0000_0300);

    // R9 drain, pop on empty, wrong command value
    phase = "R9";
    repeat (5) wr_reg(8'h1C, 32'd1);
    peek_lit("R9 empty after drain", 8'h20, 32'h0);
    peek_lit("R9 empty head reads zero", 8'h10, 32'h0);

    // R10 overflow
    phase = "R10";
    for (int i = 0; i < 18; i++) set_lines(lines ^ 64'h80);
    idle(8);
    peek_lit("R10 full and overflow", 8'h20, 32'h0000_1001);
    wr_reg(8'h1C, 32'd2);
    peek_lit("R9 wrong pop value", 8'h20, 32'h0000_1001);
    wr_reg(8'h20, 32'd1);
    peek_lit("R10 overflow cleared", 8'h20, 32'h0000_1000);
    dump_head();
    repeat (20) wr_reg(8'h1C, 32'd1);
    peek_lit("R9 pops on empty ignored", 8'h20, 32'h0);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule